// File: doc/BRIEF.md
# DMA Descriptor Fetch Sequencer

This block reloads a DMA channel's working set from memory. It reads the channel's configuration word to find the flow mode and the descriptor length. It then reads that many 16-bit halfwords through a simple request/response memory port. Each halfword is placed into the channel register that its position selects. After the last halfword, the block sets the current descriptor pointer, the current address and the two current counts, and gives a one-cycle completion pulse.

A load can begin in two ways. A start pulse captures the programmed register values from the inputs. A block-end pulse works from the values the block already holds, which lets descriptors chain. The block checks the descriptor length against the limits of the flow mode and checks the start address against the element size. Faults are reported on an error flag.

Top module: `dma_desc_loader`

## Requirements
- R1: While idle, a start pulse captures every programmed register input and begins a load, and `busy_o` rises. A start or block-end pulse that arrives while `busy_o` is high has no effect.
- R2: The element size comes from config bits [3:2]: 01 gives 2 bytes, 10 gives 4 bytes, and any other code gives 1 byte. A start address that is not a multiple of the element size sets `err_o`, and the load still completes. A start pulse without a fault clears `err_o`.
- R3: The flow mode comes from config bits [14:12]: 0 is stop, 1 is autobuffer, 4 is array, 6 is small and 7 is large. The descriptor length comes from config bits [11:8]. Stop and autobuffer need a length of 0. They issue no reads and go straight to initialisation.
- R4: A length outside the mode's range sets `err_o` and leaves the block idle, with no read and no completion pulse. The ranges are 1..7 for array, 1..8 for small and 1..9 for large. An unknown flow code has the same effect.
- R5: Array mode reads from the current descriptor pointer, and small and large modes read from the next pointer. Halfword k is read at base + 2k.
- R6: In large mode, the first and second halfwords load the low and high halves of the next pointer. In small mode, only the first halfword is used, and it loads the low half.
- R7: The remaining halfwords load these registers in this order: start address low, start address high, config, X count, X modify, Y count, Y modify.
- R8: After loading, the current descriptor pointer takes the next pointer and the current address takes the start address. `done_o` is high for exactly one cycle, 1 + 2·length cycles after the trigger edge when reads are granted at once.
- R9: Each current count takes its count register value, and a value of zero is loaded as 0xFFFF.
- R10: When idle and the held flow mode is not stop, a block-end pulse starts a load from the held registers. In stop mode, a block-end pulse is ignored.
- R11: `rd_valid_o` and `rd_addr_o` stay steady until `rd_ready_i` accepts the request. Only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse; captures the programmed values |
| blk_end_i | input | 1 | End-of-block pulse from the data mover |
| cfg_i | input | 16 | Programmed config |
| nxt_i | input | 32 | Programmed next descriptor pointer |
| cdp_i | input | 32 | Programmed current descriptor pointer |
| sa_i | input | 32 | Programmed start address |
| xcnt_i | input | 16 | Programmed X count |
| xmod_i | input | 16 | Programmed X modify |
| ycnt_i | input | 16 | Programmed Y count |
| ymod_i | input | 16 | Programmed Y modify |
| rd_valid_o | output | 1 | Halfword read request valid |
| rd_addr_o | output | 32 | Halfword read address |
| rd_ready_i | input | 1 | Request accepted |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 16 | Read data |
| cfg_o | output | 16 | Held config |
| nxt_o | output | 32 | Held next pointer |
| sa_o | output | 32 | Held start address |
| xcnt_o | output | 16 | Held X count |
| xmod_o | output | 16 | Held X modify |
| ycnt_o | output | 16 | Held Y count |
| ymod_o | output | 16 | Held Y modify |
| cur_desc_o | output | 32 | Current descriptor pointer |
| cur_addr_o | output | 32 | Current address |
| cur_x_o | output | 16 | Current X count |
| cur_y_o | output | 16 | Current Y count |
| err_o | output | 1 | Error flag |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse is due 1 + 2·length clock edges after the edge that samples the trigger when the port grants at once. A stalled port adds one edge for each refused request. `err_o` and `busy_o` settle on the trigger edge itself. The bench drives its inputs and reads the outputs on falling edges. For each load it polls `done_o` once per cycle and compares the registers only after the pulse. On the zero-stall path it also counts the exact number of cycles to the pulse. For rejected configurations it waits long enough to be sure that no pulse and no read ever appear.

// File: rtl/dma_desc_loader.sv
module dma_desc_loader (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        blk_end_i,
  input  logic [15:0] cfg_i,
  input  logic [31:0] nxt_i,
  input  logic [31:0] cdp_i,
  input  logic [31:0] sa_i,
  input  logic [15:0] xcnt_i,
  input  logic [15:0] xmod_i,
  input  logic [15:0] ycnt_i,
  input  logic [15:0] ymod_i,
  output logic        rd_valid_o,
  output logic [31:0] rd_addr_o,
  input  logic        rd_ready_i,
  input  logic        rsp_valid_i,
  input  logic [15:0] rsp_data_i,
  output logic [15:0] cfg_o,
  output logic [31:0] nxt_o,
  output logic [31:0] sa_o,
  output logic [15:0] xcnt_o,
  output logic [15:0] xmod_o,
  output logic [15:0] ycnt_o,
  output logic [15:0] ymod_o,
  output logic [31:0] cur_desc_o,
  output logic [31:0] cur_addr_o,
  output logic [15:0] cur_x_o,
  output logic [15:0] cur_y_o,
  output logic        err_o,
  output logic        busy_o,
  output logic        done_o
);
  localparam logic [2:0] FL_STOP = 3'd0;
  localparam logic [2:0] FL_AUTO = 3'd1;
  localparam logic [2:0] FL_ARR  = 3'd4;
  localparam logic [2:0] FL_SML  = 3'd6;
  localparam logic [2:0] FL_LRG  = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_INIT} st_t;
  st_t state_q;

  logic [2:0]  mode_q;
  logic [3:0]  nd_q, idx_q;
  logic [31:0] addr_q;
  logic [15:0] cfg_q, xcnt_q, xmod_q, ycnt_q, ymod_q, cx_q, cy_q;
  logic [31:0] nxt_q, sa_q, cdp_q, caddr_q;
  logic        err_q, done_q;

  wire idle = (state_q == S_IDLE);
  wire go_s = start_i & idle;
  wire go_e = blk_end_i & idle & ~start_i & (cfg_q[14:12] != FL_STOP);
  wire go   = go_s | go_e;

  wire [15:0] s_cfg = go_s ? cfg_i : cfg_q;
  wire [31:0] s_nxt = go_s ? nxt_i : nxt_q;
  wire [31:0] s_cdp = go_s ? cdp_i : cdp_q;
  wire [31:0] s_sa  = go_s ? sa_i  : sa_q;
  wire [2:0]  fl    = s_cfg[14:12];
  wire [3:0]  nd    = s_cfg[11:8];

  logic ok, mis;
  always_comb begin
    case (fl)
      FL_STOP, FL_AUTO: ok = (nd == 4'd0);
      FL_ARR:           ok = (nd != 4'd0) && (nd <= 4'd7);
      FL_SML:           ok = (nd != 4'd0) && (nd <= 4'd8);
      FL_LRG:           ok = (nd != 4'd0) && (nd <= 4'd9);
      default:          ok = 1'b0;
    endcase
    case (s_cfg[3:2])
      2'b01:   mis = s_sa[0];
      2'b10:   mis = |s_sa[1:0];
      default: mis = 1'b0;
    endcase
  end

  wire [3:0] lead = (mode_q == FL_LRG) ? 4'd2 : (mode_q == FL_SML) ? 4'd1 : 4'd0;
  wire [3:0] slot = idx_q - lead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= '0; nd_q <= '0; idx_q <= '0; addr_q <= '0;
      cfg_q   <= '0; xcnt_q <= '0; xmod_q <= '0; ycnt_q <= '0; ymod_q <= '0;
      nxt_q   <= '0; sa_q <= '0; cdp_q <= '0; caddr_q <= '0;
      cx_q    <= '0; cy_q <= '0; err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_s) begin
        cfg_q  <= cfg_i;  nxt_q  <= nxt_i;  cdp_q  <= cdp_i; sa_q <= sa_i;
        xcnt_q <= xcnt_i; xmod_q <= xmod_i; ycnt_q <= ycnt_i; ymod_q <= ymod_i;
      end
      if (go) begin
        err_q   <= (go_s ? 1'b0 : err_q) | mis | ~ok;
        mode_q  <= fl;
        nd_q    <= nd;
        idx_q   <= '0;
        addr_q  <= (fl == FL_ARR) ? s_cdp : s_nxt;
        state_q <= !ok ? S_IDLE : (nd == 4'd0) ? S_INIT : S_REQ;
      end else begin
        case (state_q)
          S_REQ: if (rd_ready_i) state_q <= S_WAIT;
          S_WAIT: if (rsp_valid_i) begin
            if (idx_q < lead) begin
              if (idx_q[0]) nxt_q[31:16] <= rsp_data_i;
              else          nxt_q[15:0]  <= rsp_data_i;
            end else begin
              case (slot)
                4'd0:    sa_q[15:0]  <= rsp_data_i;
                4'd1:    sa_q[31:16] <= rsp_data_i;
                4'd2:    cfg_q       <= rsp_data_i;
                4'd3:    xcnt_q      <= rsp_data_i;
                4'd4:    xmod_q      <= rsp_data_i;
                4'd5:    ycnt_q      <= rsp_data_i;
                default: ymod_q      <= rsp_data_i;
              endcase
            end
            idx_q   <= idx_q + 4'd1;
            addr_q  <= addr_q + 32'd2;
            state_q <= (idx_q == nd_q - 4'd1) ? S_INIT : S_REQ;
          end
          S_INIT: begin
            cdp_q   <= nxt_q;
            caddr_q <= sa_q;
            cx_q    <= (xcnt_q == 16'd0) ? 16'hFFFF : xcnt_q;
            cy_q    <= (ycnt_q == 16'd0) ? 16'hFFFF : ycnt_q;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_valid_o = (state_q == S_REQ);
  assign rd_addr_o  = addr_q;
  assign busy_o     = ~idle;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign cfg_o  = cfg_q;  assign nxt_o  = nxt_q;  assign sa_o   = sa_q;
  assign xcnt_o = xcnt_q; assign xmod_o = xmod_q; assign ycnt_o = ycnt_q;
  assign ymod_o = ymod_q;
  assign cur_desc_o = cdp_q; assign cur_addr_o = caddr_q;
  assign cur_x_o = cx_q;     assign cur_y_o = cy_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  done_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cur_addr_o == sa_o) && (cur_desc_o == nxt_o) && !busy_o);
  // R9
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cur_x_o != 16'd0) && (cur_y_o != 16'd0));
endmodule

// File: tb/dma_desc_loader_bench.sv
module dma_desc_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam logic [15:0] V_CFG [NV] = '{16'h0004, 16'h1008, 16'h0004, 16'h4700,
    16'h6800, 16'h7900, 16'h7100, 16'h4800, 16'h6000, 16'h2100, 16'h0100, 16'h0004};
  localparam logic [31:0] V_NXT [NV] = '{32'h8000, 32'h8100, 32'h8200, 32'h8300,
    32'h3000, 32'h4000, 32'h4800, 32'h8400, 32'h8500, 32'h8600, 32'h8700, 32'h8800};
  localparam logic [31:0] V_CDP [NV] = '{32'h10, 32'h20, 32'h30, 32'h2000,
    32'h50, 32'h60, 32'h70, 32'h80, 32'h90, 32'hA0, 32'hB0, 32'hC0};
  localparam logic [31:0] V_SA [NV] = '{32'h100, 32'h102, 32'h200, 32'h300,
    32'h400, 32'h500, 32'h600, 32'h700, 32'h800, 32'h900, 32'hA00, 32'h101};
  localparam logic V_STL [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, blk_end = 1'b0;
  logic [15:0] cfg = '0, xcnt = 16'h0010, xmod = 16'h0002, ycnt = 16'h0000, ymod = 16'h0004;
  logic [31:0] nxt = '0, cdp = '0, sa = '0;
  logic rd_v, rsp_v = 1'b0;
  logic [31:0] rd_a;
  logic [15:0] rsp_d = '0;
  logic force_low = 1'b0, stall_mode = 1'b0;
  logic [1:0] tick = '0;
  logic [15:0] o_cfg, o_xc, o_xm, o_yc, o_ym, o_cx, o_cy;
  logic [31:0] o_nxt, o_sa, o_cd, o_ca;
  logic o_err, o_busy, o_done;
  wire rd_rdy = !force_low && (!stall_mode || tick[1]);

  int checks = 0, fails = 0;
  logic [15:0] e_cfg, e_xc, e_xm, e_yc, e_ym, e_cx, e_cy;
  logic [31:0] e_nxt, e_sa, e_cd, e_ca;
  logic e_err, e_ok;
  int e_nd;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_desc_loader u_dma_desc_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .blk_end_i(blk_end),
    .cfg_i(cfg), .nxt_i(nxt), .cdp_i(cdp), .sa_i(sa),
    .xcnt_i(xcnt), .xmod_i(xmod), .ycnt_i(ycnt), .ymod_i(ymod),
    .rd_valid_o(rd_v), .rd_addr_o(rd_a), .rd_ready_i(rd_rdy),
    .rsp_valid_i(rsp_v), .rsp_data_i(rsp_d),
    .cfg_o(o_cfg), .nxt_o(o_nxt), .sa_o(o_sa), .xcnt_o(o_xc), .xmod_o(o_xm),
    .ycnt_o(o_yc), .ymod_o(o_ym), .cur_desc_o(o_cd), .cur_addr_o(o_ca),
    .cur_x_o(o_cx), .cur_y_o(o_cy), .err_o(o_err), .busy_o(o_busy), .done_o(o_done));

  function automatic logic [15:0] memf(input logic [31:0] a);
    return a[16:1] * 16'd7 + 16'h2B01;
  endfunction

  always @(posedge clk) begin
    tick  <= tick + 2'd1;
    rsp_v <= rd_v && rd_rdy;
    rsp_d <= memf(rd_a);
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] c, input logic [31:0] n, input logic [31:0] d, input logic [31:0] s);
    logic [31:0] base;
    int lead;
    e_cfg = c; e_nxt = n; e_sa = s; e_xc = xcnt; e_xm = xmod; e_yc = ycnt; e_ym = ymod;
    e_nd = int'(c[11:8]);
    case (c[14:12])
      3'd0, 3'd1: e_ok = (e_nd == 0);
      3'd4: e_ok = (e_nd >= 1 && e_nd <= 7);
      3'd6: e_ok = (e_nd >= 1 && e_nd <= 8);
      3'd7: e_ok = (e_nd >= 1 && e_nd <= 9);
      default: e_ok = 1'b0;
    endcase
    e_err = !e_ok || (c[3:2] == 2'b01 && s[0]) || (c[3:2] == 2'b10 && s[1:0] != 2'b00);
    lead = (c[14:12] == 3'd7) ? 2 : (c[14:12] == 3'd6) ? 1 : 0;
    base = (c[14:12] == 3'd4) ? d : n;
    if (e_ok) for (int k = 0; k < e_nd; k++) begin
      logic [15:0] v;
      v = memf(base + 32'(2*k));
      if (k < lead) begin
        if (k == 1) e_nxt[31:16] = v; else e_nxt[15:0] = v;
      end else case (k - lead)
        0: e_sa[15:0] = v;
        1: e_sa[31:16] = v;
        2: e_cfg = v;
        3: e_xc = v;
        4: e_xm = v;
        5: e_yc = v;
        default: e_ym = v;
      endcase
    end
    e_cd = e_nxt; e_ca = e_sa;
    e_cx = (e_xc == 0) ? 16'hFFFF : e_xc;
    e_cy = (e_yc == 0) ? 16'hFFFF : e_yc;
  endtask

  task automatic wait_done(output int cyc, output logic got);
    got = 1'b0; cyc = 0;
    for (int c = 0; c < 300 && !got; c++) begin
      @(negedge clk); cyc++;
      if (o_done) got = 1'b1;
    end
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic check_loaded(input string tag);
    chk(o_err == e_err, {tag, " R2 err"}, 32'(o_err), 32'(e_err));
    chk(o_nxt == e_nxt, {tag, " R6 next ptr"}, o_nxt, e_nxt);
    chk(o_sa == e_sa, {tag, " R7 start addr"}, o_sa, e_sa);
    chk(o_cfg == e_cfg, {tag, " R7 config"}, 32'(o_cfg), 32'(e_cfg));
    chk(o_xc == e_xc && o_xm == e_xm && o_ym == e_ym, {tag, " R7 x/ymod"}, {o_xc, o_ym}, {e_xc, e_ym});
    chk(o_cd == e_cd && o_ca == e_ca, {tag, " R8 cur desc/addr"}, o_ca, e_ca);
    chk(o_cx == e_cx && o_cy == e_cy, {tag, " R9 cur counts"}, {o_cx, o_cy}, {e_cx, e_cy});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic got;
    repeat (3) @(negedge clk);
    chk(!o_busy && !o_done && !o_err && !rd_v, "R1 reset idle", {o_busy, o_done, o_err, rd_v}, 0);
    chk(o_cx == 0 && o_ca == 0, "R8 reset cur", o_ca, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cfg = V_CFG[i]; nxt = V_NXT[i]; cdp = V_CDP[i]; sa = V_SA[i]; stall_mode = V_STL[i];
      model(cfg, nxt, cdp, sa);
      pulse_start();
      if (e_ok) begin
        wait_done(cyc, got);
        chk(got, $sformatf("vec%0d R3 done", i), 32'(got), 1);
        check_loaded($sformatf("vec%0d", i));
      end else begin
        got = 1'b0;
        for (int c = 0; c < 30; c++) begin
          @(negedge clk);
          if (o_done || rd_v || o_busy) got = 1'b1;
        end
        chk(!got, $sformatf("vec%0d R4 no activity", i), 32'(got), 0);
        chk(o_err, $sformatf("vec%0d R4 err", i), 32'(o_err), 1);
      end
      stall_mode = 1'b0;
      @(negedge clk);
    end

    // R8 latency: array length 3, no stall -> 1+2*3 cycles
    cfg = 16'h4300; cdp = 32'h1200; nxt = 32'h1300; sa = 32'h40;
    model(cfg, nxt, cdp, sa);
    pulse_start();
    wait_done(cyc, got);
    chk(got && cyc == 7, "R8 latency", cyc, 7);
    @(negedge clk);
    chk(!o_done, "R8 single pulse", 32'(o_done), 0);

    // R11 + R1: stalled request stays put; second start ignored
    force_low = 1'b1;
    cfg = 16'h4100; cdp = 32'h5000; nxt = 32'h5100; sa = 32'h0;
    model(cfg, nxt, cdp, sa);
    pulse_start();
    repeat (4) @(negedge clk);
    chk(rd_v && rd_a == 32'h5000, "R11 request held", rd_a, 32'h5000);
    cfg = 16'h6200; cdp = 32'h6000; nxt = 32'h6100;
    pulse_start();
    chk(rd_v && rd_a == 32'h5000, "R1 start while busy ignored", rd_a, 32'h5000);
    force_low = 1'b0;
    wait_done(cyc, got);
    chk(got, "R1 done after stall", 32'(got), 1);
    check_loaded("busy");

    // R10: chained array reload from held current pointer
    cfg = 16'h4200; cdp = 32'h7000; nxt = 32'h7100; sa = 32'h0;
    pulse_start();
    wait_done(cyc, got);
    chk(o_sa == {memf(32'h7002), memf(32'h7000)}, "R5 array base cur ptr", o_sa, {memf(32'h7002), memf(32'h7000)});
    blk_end = 1'b1; @(negedge clk); blk_end = 1'b0;
    wait_done(cyc, got);
    chk(got && o_ca == {memf(32'h7102), memf(32'h7100)}, "R10 chained reload", o_ca, {memf(32'h7102), memf(32'h7100)});

    // R10: autobuffer reloads, stop ignores block end
    cfg = 16'h1000; sa = 32'h900; xcnt = 16'h0000;
    pulse_start();
    wait_done(cyc, got);
    chk(o_cx == 16'hFFFF, "R9 zero x count", 32'(o_cx), 32'hFFFF);
    blk_end = 1'b1; @(negedge clk); blk_end = 1'b0;
    wait_done(cyc, got);
    chk(got && o_ca == 32'h900, "R10 auto reload", o_ca, 32'h900);
    cfg = 16'h0000; sa = 32'hA00;
    pulse_start();
    wait_done(cyc, got);
    blk_end = 1'b1; @(negedge clk); blk_end = 1'b0;
    chk(!o_busy, "R10 stop ignores block end", 32'(o_busy), 0);
    got = 1'b0;
    for (int c = 0; c < 10; c++) begin @(negedge clk); if (o_done) got = 1'b1; end
    chk(!got, "R10 stop no done", 32'(got), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule